// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Character Buffer

This block takes an asynchronous serial input line, conditions it through a two-flop synchroniser, and recovers character frames from it. It counts pulses of an oversampling strobe that runs at sixteen times the bit rate. It finds the start bit, samples every data bit near its centre, and checks the stop bit. The start and stop bits are stripped. The data bits, together with per-character error flags, go into a receive buffer that the host drains one word at a time.

Each buffered word carries its own error tag next to the character, so the host always knows which character was damaged. A mode input selects between a sixteen-entry buffer and a single-character holding register. Two flags report whether the buffer is empty and whether it is full. A character that arrives while the buffer is full is lost. The next character that is stored is marked as following that loss.

The receive controller is a five-state machine. The states are IDLE, START, DATA, STOP and WAIT_HIGH.
- IDLE goes to START when the synchronised line is low.
- START goes to DATA if the line is still low at the centre strobe of the start bit. If the line is high there, START goes back to IDLE.
- DATA goes to STOP after the last data bit of the selected width has been sampled.
- STOP goes to IDLE when the stop bit is sampled high. It goes to WAIT_HIGH when the stop bit is sampled low.
- WAIT_HIGH goes to IDLE once the line is high again.

Top module: `uart_rx_efifo`

## Requirements
- R1: A falling edge on `rxd` starts a character only if the synchronised line is still low at the 8th strobe counted after the edge is seen. Otherwise the receiver goes back to idle and nothing is stored.
- R2: Data bits arrive least-significant first and are each sampled 16 strobes after the previous sample. `wlen` selects the character width: 00 = 5 bits, 01 = 6 bits, 10 = 7 bits, 11 = 8 bits. The unused upper bits of the character byte read as 0.
- R3: Layout of `rd_data`:
  - Bits 7:0 hold the character.
  - Bit 8 is the framing flag.
  - Bit 9 is the parity flag. It always reads 0, because no parity bit is expected.
  - Bit 10 is the break flag.
  - Bit 11 is the overrun flag.
  - `rd_data` is all zeros while the buffer is empty.
- R4: A stop bit sampled low sets bit 8 of that character's word.
- R5: A frame whose data bits and stop bit are all low sets both bit 10 and bit 8. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: With `fifo_en` = 1, up to 16 characters are buffered and read back in arrival order.
- R7: With `fifo_en` = 0, the buffer holds exactly one character.
- R8: `rx_empty` is 1 exactly when no character is buffered.
- R9: `rx_full` is 1 when the number of buffered characters reaches the capacity of the selected mode. In single mode this happens after one character.
- R10: A character that completes while the buffer is full, with no read in the same cycle, is discarded. Bit 11 is set on the next character stored, and only on that one.
- R11: When a character completes in the same cycle as a read of a full buffer, the read removes the oldest entry and the new character is stored with no overrun mark.
- R12: A read pulse while the buffer is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling strobe, 16 per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| wlen | input | 2 | Character width code (5 to 8 bits) |
| fifo_en | input | 1 | 1 = 16-entry buffer, 0 = single character |
| rd_en | input | 1 | Pop the oldest buffered word |
| rd_data | output | 12 | Oldest word: character plus error tag |
| rx_empty | output | 1 | Buffer holds no character |
| rx_full | output | 1 | Buffer is at capacity |

## Verification
Two functions can fall in the same cycle: the completion of a character and a host read. The case that matters is a completion against a full buffer. The bench controls the strobe, so it knows the exact strobe of the stop-bit sample. It raises `rd_en` for the single clock in which the new character reaches the buffer. The outcome is then judged in three ways:
- `rx_full` must stay high.
- The word popped in that cycle must be the oldest one.
- When the buffer is drained, the new character must be last and must carry no overrun mark.

Directed runs of the same completion with no read confirm the opposite outcome: the character is dropped and the next stored word carries the mark.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    // Tag bit positions above the character in a read word
    localparam int TAG_FRAME   = 8;
    localparam int TAG_PARITY  = 9;
    localparam int TAG_BREAK   = 10;
    localparam int TAG_OVERRUN = 11;

    typedef struct packed {
        logic              brk;
        logic              par;
        logic              frm;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic [1:0] wlen,
    output logic       frm_vld,
    output rx_char_t   frm
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        idx_q;
    logic [CHAR_W-1:0] shreg_q;

    logic [3:0]        nbits;
    logic [2:0]        last_idx;
    logic [CHAR_W-1:0] aligned;
    logic              at_mid, at_last;

    assign nbits    = 4'd5 + {2'b00, wlen};
    assign last_idx = 3'(nbits - 4'd1);
    assign aligned  = shreg_q >> (4'd8 - nbits);
    assign at_mid   = tick && (cnt_q == CNT_MID);
    assign at_last  = tick && (cnt_q == CNT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:      if (!rx_s) state_d = RX_START;
            RX_START:     if (at_mid) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:      if (at_last && idx_q == last_idx) state_d = RX_STOP;
            RX_STOP:      if (at_last) state_d = rx_s ? RX_IDLE : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (rx_s) state_d = RX_IDLE;
            default:      state_d = RX_IDLE;
        endcase
    end

    // Counters, shift register and character output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            frm_vld <= 1'b0;
            frm     <= '0;
        end else begin
            frm_vld <= 1'b0;
            unique case (state_q)
                RX_IDLE, RX_WAIT_HIGH: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                end
                RX_START: begin
                    if (tick) cnt_q <= at_mid ? '0 : cnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (at_last) begin
                        cnt_q   <= '0;
                        shreg_q <= {rx_s, shreg_q[CHAR_W-1:1]};
                        idx_q   <= idx_q + 3'd1;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_last) begin
                        cnt_q    <= '0;
                        frm_vld  <= 1'b1;
                        frm.data <= aligned;
                        frm.frm  <= !rx_s;
                        frm.par  <= 1'b0;
                        frm.brk  <= !rx_s && (aligned == '0);
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_en,
    input  logic        push_vld,
    input  rx_char_t    push_char,
    input  logic        pop_req,
    output logic [11:0] rd_data,
    output logic        empty,
    output logic        full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [11:0]   mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
    logic [CW-1:0] count_q, cap;
    logic          ovr_q, pop, accept, drop;

    assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
    assign empty  = (count_q == '0);
    assign full   = (count_q >= cap);
    assign pop    = pop_req && !empty;
    assign accept = push_vld && (!full || pop);
    assign drop   = push_vld && !accept;

    generate
        if (DEPTH == (1 << AW)) begin : g_pow2
            assign wr_nxt = wr_q + 1'b1;
            assign rd_nxt = rd_q + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (accept) mem[wr_q] <= {ovr_q, push_char};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (accept) wr_q <= wr_nxt;
            if (pop)    rd_q <= rd_nxt;
            unique case ({accept, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (accept)    ovr_q <= 1'b0;
            else if (drop) ovr_q <= 1'b1;
        end
    end

    assign rd_data = empty ? 12'h000 : mem[rd_q];
endmodule

// File: rtl/uart_rx_efifo.sv
module uart_rx_efifo
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        rxd,
    input  logic [1:0]  wlen,
    input  logic        fifo_en,
    input  logic        rd_en,
    output logic [11:0] rd_data,
    output logic        rx_empty,
    output logic        rx_full
);
    logic     rx_s;
    logic     frm_vld;
    rx_char_t frm;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .rx_s   (rx_s),
        .wlen   (wlen),
        .frm_vld(frm_vld),
        .frm    (frm)
    );

    uart_rx_buf #(.DEPTH(FIFO_DEPTH)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .push_vld (frm_vld),
        .push_char(frm),
        .pop_req  (rd_en),
        .rd_data  (rd_data),
        .empty    (rx_empty),
        .full     (rx_full)
    );
endmodule

// File: rtl/uart_rx_efifo_chk.sv
module uart_rx_efifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_en,
    input logic        rd_en,
    input logic        frm_vld,
    input logic [11:0] rd_data,
    input logic        rx_empty,
    input logic        rx_full
);
    assert_empty_not_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full));

    assert_no_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_empty |-> !rd_data[9]);

    assert_break_frames_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_empty && rd_data[10]) |-> rd_data[8]);

    assert_single_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !rx_empty) |-> rx_full);

    assert_push_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !rx_empty);

    assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !frm_vld) |=> rx_empty);

    assert_drop_keeps_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && frm_vld && !rd_en) |=> (rx_full || (fifo_en != $past(fifo_en))));
endmodule

bind uart_rx_efifo uart_rx_efifo_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .rd_en   (rd_en),
    .frm_vld (frm_vld),
    .rd_data (rd_data),
    .rx_empty(rx_empty),
    .rx_full (rx_full)
);

// File: tb/tb_uart_rx_efifo.sv
module tb_uart_rx_efifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        rxd = 1'b1;
    logic [1:0]  wlen = 2'b11;
    logic        fifo_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_data;
    logic        rx_empty, rx_full;

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];
    bit model_ovr = 0;
    logic [11:0] popped;

    always #5 clk = ~clk;

    uart_rx_efifo dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .wlen(wlen),
        .fifo_en(fifo_en), .rd_en(rd_en), .rd_data(rd_data),
        .rx_empty(rx_empty), .rx_full(rx_full)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_word(input logic [7:0] d, input int nb,
                                    input logic stop, input bit ovr);
        logic [7:0] dm;
        logic ferr, brk;
        dm   = d & 8'((1 << nb) - 1);
        ferr = !stop;
        brk  = ferr && (dm == 8'h00);
        return int'({ovr, brk, 1'b0, ferr, dm});
    endfunction

    function automatic int cap();
        return fifo_en ? 16 : 1;
    endfunction

    task automatic send_bit(input logic lvl, input bit pop9);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); rxd = lvl; tick = 1'b1; rd_en = 1'b0;
            @(negedge clk); tick = 1'b0;
            if (pop9 && k == 9) begin
                popped = rd_data;
                rd_en = 1'b1;
            end
        end
        rd_en = 1'b0;
    endtask

    // Send one character and update the model of the buffer
    task automatic rx_char(input logic [7:0] d, input int nb, input logic stop,
                           input bit pop, input string req);
        wlen = 2'(nb - 5);
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i], 1'b0);
        send_bit(stop, pop);
        if (!stop) send_bit(1'b1, 1'b0);
        if (pop) check({req, " popped"}, int'(popped), exp_q.pop_front());
        if (exp_q.size() < cap()) begin
            exp_q.push_back(exp_word(d, nb, stop, model_ovr));
            model_ovr = 0;
        end else begin
            model_ovr = 1;
        end
    endtask

    task automatic flags(input string req);
        @(negedge clk);
        check({req, " empty"}, int'(rx_empty), int'(exp_q.size() == 0));
        check({req, " full"}, int'(rx_full), int'(exp_q.size() >= cap()));
    endtask

    task automatic read_one(input string req);
        int w;
        @(negedge clk);
        w = int'(rd_data);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, w, exp_q.pop_front());
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) read_one(req);
        flags(req);
    endtask

    initial begin
        #(10 * 200000);
        n_err++;
        $display("FAIL watchdog expired (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 / R3: reset state
        check("R8 reset empty", int'(rx_empty), 1);
        check("R9 reset full", int'(rx_full), 0);
        check("R3 reset data", int'(rd_data), 0);

        // R7 / R9: single-entry mode
        fifo_en = 1'b0;
        rx_char(8'hA5, 8, 1'b1, 0, "R7");
        flags("R7 R9 single full");
        read_one("R2 R7 char");
        flags("R8 empty after read");

        // R10: overrun in single mode
        rx_char(8'h3C, 8, 1'b1, 0, "R10");
        rx_char(8'h55, 8, 1'b1, 0, "R10");
        flags("R10 held full");
        read_one("R10 survivor");
        rx_char(8'h12, 8, 1'b1, 0, "R10");
        read_one("R10 marked");
        rx_char(8'h34, 8, 1'b1, 0, "R10");
        read_one("R10 mark once");

        // R2: word widths
        fifo_en = 1'b1;
        rx_char(8'hFF, 5, 1'b1, 0, "R2");
        rx_char(8'hEA, 6, 1'b1, 0, "R2");
        rx_char(8'hD5, 7, 1'b1, 0, "R2");
        drain("R2 width");

        // R4 / R5: framing and break, then recovery
        rx_char(8'h81, 8, 1'b0, 0, "R4");
        rx_char(8'h00, 8, 1'b0, 0, "R5");
        rx_char(8'h77, 8, 1'b1, 0, "R5");
        drain("R4 R5 tags");

        // R1: short glitch is not a start bit
        for (int k = 0; k < 36; k++) begin
            @(negedge clk); rxd = (k < 4) ? 1'b0 : 1'b1; tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        flags("R1 glitch ignored");
        check("R1 glitch data", int'(rd_data), 0);

        // R12: read of empty buffer
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        flags("R12 empty read");
        rx_char(8'h5A, 8, 1'b1, 0, "R12");
        read_one("R12 next char");

        // R6 / R9 / R11: fill, then completion coincident with a read
        for (int i = 0; i < 16; i++) rx_char(8'(i * 17 + 3), 8, 1'b1, 0, "R6");
        flags("R9 deep full");
        rx_char(8'hC3, 8, 1'b1, 1, "R11");
        flags("R11 still full");
        drain("R6 R11 order");

        // R10 in deep mode
        for (int i = 0; i < 16; i++) rx_char(8'(i + 64), 8, 1'b1, 0, "R6");
        rx_char(8'h99, 8, 1'b1, 0, "R10");
        read_one("R10 deep head");
        rx_char(8'h66, 8, 1'b1, 0, "R10");
        drain("R10 deep mark");

        // Random traffic
        for (int r = 0; r < 8; r++) begin
            int n;
            n = int'($urandom_range(1, 6));
            for (int i = 0; i < n; i++)
                rx_char(8'($urandom), int'($urandom_range(5, 8)),
                        ($urandom_range(0, 5) != 0), 0, "R2 R4 R6 random");
            drain("R6 random drain");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule